// File: doc/BRIEF.md
# Logical Device I/O Port Decoder with Conflict Probe

This block is the port decoder for one logical device on a card. Software programs up to eight 16-bit I/O base addresses, an enable bit and a conflict-probe control through a byte-wide indexed configuration port. Configuration access is accepted only while the card-level logic holds `cfg_en` high. The decoder compares each bus I/O cycle against the programmed windows. Each window covers eight consecutive ports, starting at its base.

While the device is enabled, a matching read or write raises a device select for the function behind the decoder. While the device is disabled and the conflict probe is armed, a matching read is answered by the decoder itself with a fixed byte. The host reads that byte back to find out whether another agent also decodes the same ports. Both answers are combinational and valid in the cycle of the bus strobe.

Top module: `ldev_io_decode`

## Requirements
- R1: After a synchronous active-low reset, every base, the enable bit and both probe bits are zero. `cfg_rdata`, `dev_sel`, `rd_drive` and `rd_data` are then all zero.
- R2: A configuration write takes effect at the clock edge only when both `cfg_en` and `cfg_wr` are high. While `cfg_en` is low, writes leave all state unchanged and `cfg_rdata` reads 0.
- R3: Window n (0..7) has two registers. Index 0x60+2n holds base bits [15:8] and index 0x61+2n holds base bits [7:0]. Both read back exactly what was written.
- R4: Index 0x30 bit 0 is the device enable. It reads back in bit 0, and bits [7:1] always read 0.
- R5: Index 0x31 bit 1 arms the conflict probe and bit 0 selects the probe byte. They read back in those bits, and bits [7:2] always read 0.
- R6: A window with base B matches bus addresses B through B+7 inclusive. It does not match B-1 or B+8, and it never wraps past 0xFFFF.
- R7: A window whose base is 0x0000 matches no address.
- R8: `dev_sel` is high exactly when the device is enabled, some window matches `bus_addr`, and `bus_rd` or `bus_wr` is high.
- R9: With the device disabled and the probe armed, a read in a matching window raises `rd_drive` in the same cycle. `rd_data` is then 0x55 when index 0x31 bit 0 is 1, and 0xAA when it is 0. Writes never raise `rd_drive`, and `rd_data` is 0 whenever `rd_drive` is low.
- R10: While the device is enabled, the probe answer is suppressed: `rd_drive` stays low even if the probe is armed.
- R11: With `cfg_en` high, every index other than 0x30, 0x31 and 0x60..0x6F reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Configuration access permitted |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_idx | input | 8 | Configuration register index |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Read-back of the indexed register |
| bus_addr | input | 16 | Bus I/O port address |
| bus_rd | input | 1 | Bus I/O read strobe |
| bus_wr | input | 1 | Bus I/O write strobe |
| dev_sel | output | 1 | Device select for the enabled function |
| rd_data | output | 8 | Probe answer byte |
| rd_drive | output | 1 | Probe answer valid, drive the data bus |

## Verification
The bench builds the block with its defaults: eight windows, 16-bit addresses and an eight-port span. With these values the full index range 0x60..0x6F is reachable, and so is a base near 0xFFFF, whose window must stop at the top of the address space instead of wrapping. An unaligned base is also used, to expose any decoder that masks low address bits instead of comparing the offset. A behavioural model recomputes the select, the probe answer and the read-back every cycle. That makes it possible to sweep addresses on both sides of every window edge while the enable and probe bits change.

// File: rtl/ldio_pkg.sv
// Shared constants and types for the logical-device I/O decoder.
// Assumes a byte-wide configuration data path.
package ldio_pkg;
    localparam logic [7:0] IDX_ENABLE = 8'h30;
    localparam logic [7:0] IDX_PROBE  = 8'h31;
    localparam logic [7:0] IDX_BASE0  = 8'h60;
    localparam logic [7:0] PROBE_SET  = 8'h55;
    localparam logic [7:0] PROBE_CLR  = 8'hAA;

    typedef struct packed {
        logic enable;
        logic probe_arm;
        logic probe_sel;
    } ldio_ctrl_t;
endpackage

// File: rtl/ldio_cfg_regs.sv
// Configuration register file: window bases, enable and probe control,
// written and read back through a byte-wide indexed port.
// Assumes 9 <= ADDR_W <= 16 so that a base spans exactly two bytes.
module ldio_cfg_regs
    import ldio_pkg::*;
#(
    parameter int NUM_RANGES = 8,
    parameter int ADDR_W     = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_en,
    input  logic                              cfg_wr,
    input  logic [7:0]                        cfg_idx,
    input  logic [7:0]                        cfg_wdata,
    output logic [7:0]                        cfg_rdata,
    output logic [NUM_RANGES-1:0][ADDR_W-1:0] bases,
    output ldio_ctrl_t                        ctrl
);
    localparam int HI_W = ADDR_W - 8;

    logic wr_ok;
    assign wr_ok = cfg_en & cfg_wr;

    // Control bits: enable at the enable index, probe bits at the probe index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_ok) begin
            if (cfg_idx == IDX_ENABLE) ctrl.enable <= cfg_wdata[0];
            if (cfg_idx == IDX_PROBE) begin
                ctrl.probe_arm <= cfg_wdata[1];
                ctrl.probe_sel <= cfg_wdata[0];
            end
        end
    end

    for (genvar g = 0; g < NUM_RANGES; g++) begin : g_base
        localparam logic [7:0] HI_IDX = IDX_BASE0 + 8'(2 * g);
        localparam logic [7:0] LO_IDX = IDX_BASE0 + 8'(2 * g + 1);
        // One window base: high byte and low byte written separately.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bases[g] <= '0;
            end else if (wr_ok) begin
                if (cfg_idx == HI_IDX) bases[g][ADDR_W-1:8] <= cfg_wdata[HI_W-1:0];
                if (cfg_idx == LO_IDX) bases[g][7:0]        <= cfg_wdata;
            end
        end
    end

    // Read-back mux; unmapped indexes and closed access return zero.
    always_comb begin
        cfg_rdata = '0;
        if (cfg_en) begin
            if (cfg_idx == IDX_ENABLE) cfg_rdata = {7'b0, ctrl.enable};
            if (cfg_idx == IDX_PROBE)  cfg_rdata = {6'b0, ctrl.probe_arm, ctrl.probe_sel};
            for (int i = 0; i < NUM_RANGES; i++) begin
                if (cfg_idx == IDX_BASE0 + 8'(2 * i))
                    cfg_rdata = 8'(bases[i][ADDR_W-1:8]);
                if (cfg_idx == IDX_BASE0 + 8'(2 * i + 1))
                    cfg_rdata = bases[i][7:0];
            end
        end
    end

    // R2: with access closed, no register moves.
    a_r2_closed_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> ($stable(ctrl) && $stable(bases)));
    // R4: upper bits of the enable register read zero.
    a_r4_enable_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && cfg_idx == IDX_ENABLE) |-> (cfg_rdata[7:1] == 7'd0));
    // R5: upper bits of the probe register read zero.
    a_r5_probe_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && cfg_idx == IDX_PROBE) |-> (cfg_rdata[7:2] == 6'd0));
endmodule

// File: rtl/ldio_range_match.sv
// Window comparators: one per programmed base, each matching SPAN
// consecutive ports from its base without wrap; base zero disables it.
// Assumes SPAN_LOG2 < ADDR_W.
module ldio_range_match #(
    parameter int NUM_RANGES = 8,
    parameter int ADDR_W     = 16,
    parameter int SPAN_LOG2  = 3
) (
    input  logic [NUM_RANGES-1:0][ADDR_W-1:0] bases,
    input  logic [ADDR_W-1:0]                 addr,
    output logic [NUM_RANGES-1:0]             hit_vec,
    output logic                              any_hit
);
    for (genvar g = 0; g < NUM_RANGES; g++) begin : g_cmp
        logic [ADDR_W:0] diff;
        // Offset of the address from this base; the top bit flags a borrow.
        always_comb begin
            diff = {1'b0, addr} - {1'b0, bases[g]};
            hit_vec[g] = (bases[g] != '0) && !diff[ADDR_W]
                       && (diff[ADDR_W-1:SPAN_LOG2] == '0);
        end
    end

    assign any_hit = |hit_vec;
endmodule

// File: rtl/ldio_respond.sv
// Response stage: device select while enabled, fixed probe byte while
// disabled with the probe armed. Purely combinational.
module ldio_respond
    import ldio_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  ldio_ctrl_t ctrl,
    input  logic       any_hit,
    input  logic       bus_rd,
    input  logic       bus_wr,
    output logic       dev_sel,
    output logic [7:0] rd_data,
    output logic       rd_drive
);
    // Select and probe answer from the match and the control bits.
    always_comb begin
        dev_sel  = ctrl.enable && any_hit && (bus_rd || bus_wr);
        rd_drive = !ctrl.enable && ctrl.probe_arm && any_hit && bus_rd;
        rd_data  = rd_drive ? (ctrl.probe_sel ? PROBE_SET : PROBE_CLR) : 8'h00;
    end

    // R8: select only for an enabled device on a live strobe.
    a_r8_sel_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        dev_sel |-> (ctrl.enable && (bus_rd || bus_wr)));
    // R10: no probe answer while the device is enabled.
    a_r10_no_probe_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.enable |-> !rd_drive);
    // R9: probe answer only on reads, and only one of the two bytes.
    a_r9_probe_byte: assert property (@(posedge clk) disable iff (!rst_n)
        rd_drive |-> (bus_rd && (rd_data == PROBE_SET || rd_data == PROBE_CLR)));
    // R9: data bus idle when not driving.
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_drive |-> (rd_data == 8'h00));
endmodule

// File: rtl/ldev_io_decode.sv
// Top of the logical-device I/O decoder: register file, window
// comparators and response stage. Assumes cfg_en comes from card-level
// state logic and bus strobes are single-cycle qualified.
module ldev_io_decode
    import ldio_pkg::*;
#(
    parameter int NUM_RANGES = 8,
    parameter int ADDR_W     = 16,
    parameter int SPAN_LOG2  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_idx,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic              dev_sel,
    output logic [7:0]        rd_data,
    output logic              rd_drive
);
    logic [NUM_RANGES-1:0][ADDR_W-1:0] bases;
    logic [NUM_RANGES-1:0]             hit_vec;
    logic                              any_hit;
    ldio_ctrl_t                        ctrl;

    ldio_cfg_regs #(.NUM_RANGES(NUM_RANGES), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_wr(cfg_wr),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .bases(bases), .ctrl(ctrl)
    );

    ldio_range_match #(.NUM_RANGES(NUM_RANGES), .ADDR_W(ADDR_W),
                       .SPAN_LOG2(SPAN_LOG2)) u_match (
        .bases(bases), .addr(bus_addr), .hit_vec(hit_vec), .any_hit(any_hit)
    );

    ldio_respond u_resp (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .any_hit(any_hit),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .dev_sel(dev_sel),
        .rd_data(rd_data), .rd_drive(rd_drive)
    );

    // R10: select and probe answer are never both active.
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(dev_sel && rd_drive));
    // R7/R6: any response implies at least one window matched.
    a_r6_response_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_sel || rd_drive) |-> $countones(hit_vec) > 0);
endmodule

// File: tb/ldev_io_decode_tb.sv
`timescale 1ns/1ps
module ldev_io_decode_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0, cfg_wr = 1'b0;
    logic [7:0]  cfg_idx = '0, cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic [15:0] bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic        dev_sel, rd_drive;
    logic [7:0]  rd_data;

    int vectors = 0;
    int fails = 0;

    // Reference state
    int base_m[8];
    bit en_m, arm_m, psel_m;

    always #2.5 clk = ~clk;

    ldev_io_decode u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_wr(cfg_wr),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .dev_sel(dev_sel), .rd_data(rd_data), .rd_drive(rd_drive)
    );

    function automatic bit model_hit(int a);
        for (int i = 0; i < 8; i++)
            if (base_m[i] != 0 && a >= base_m[i] && a < base_m[i] + 8) return 1;
        return 0;
    endfunction

    function automatic int model_rdata(bit en, int idx);
        if (!en) return 0;
        if (idx == 'h30) return int'(en_m);
        if (idx == 'h31) return (int'(arm_m) << 1) | int'(psel_m);
        if (idx >= 'h60 && idx < 'h70) begin
            int i = (idx - 'h60) / 2;
            return ((idx % 2) == 0) ? (base_m[i] >> 8) & 'hFF : base_m[i] & 'hFF;
        end
        return 0;
    endfunction

    task automatic model_write(int idx, int wd);
        if (idx == 'h30) en_m = wd[0];
        if (idx == 'h31) begin arm_m = wd[1]; psel_m = wd[0]; end
        if (idx >= 'h60 && idx < 'h70) begin
            int i = (idx - 'h60) / 2;
            if ((idx % 2) == 0) base_m[i] = (base_m[i] & 'hFF) | (wd << 8);
            else                base_m[i] = (base_m[i] & 'hFF00) | wd;
        end
    endtask

    task automatic chk(string tag, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive, compare mid-cycle, commit model at the edge.
    task automatic step(string tag, bit en, bit wr, int idx, int wd,
                        int a, bit rd, bit bw);
        bit h, xs, xd;
        cfg_en = en; cfg_wr = wr; cfg_idx = 8'(idx); cfg_wdata = 8'(wd);
        bus_addr = 16'(a); bus_rd = rd; bus_wr = bw;
        @(negedge clk);
        h  = model_hit(a);
        xs = en_m && h && (rd || bw);
        xd = !en_m && arm_m && h && rd;
        chk(tag, "dev_sel", int'(dev_sel), int'(xs));
        chk(tag, "rd_drive", int'(rd_drive), int'(xd));
        chk(tag, "rd_data", int'(rd_data), xd ? (psel_m ? 'h55 : 'hAA) : 0);
        chk(tag, "cfg_rdata", int'(cfg_rdata), model_rdata(en, idx));
        @(posedge clk);
        if (rst_n && en && wr) model_write(idx, wd);
        #1;
    endtask

    task automatic cwr(string tag, int idx, int wd);
        step(tag, 1, 1, idx, wd, 0, 0, 0);
    endtask

    task automatic crd(string tag, int idx);
        step(tag, 1, 0, idx, 0, 0, 0, 0);
    endtask

    task automatic sweep(string tag, int b, bit bw);
        for (int d = -2; d < 11; d++) step(tag, 0, 0, 0, 0, (b + d) & 'hFFFF, !bw, bw);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < 8; i++) base_m[i] = 0;
        en_m = 0; arm_m = 0; psel_m = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        crd("R1", 'h30); crd("R1", 'h31); crd("R1", 'h60);
        step("R1", 0, 0, 0, 0, 'h0000, 1, 0);

        // R2: closed access ignores writes and reads zero
        step("R2", 0, 1, 'h30, 'h01, 0, 0, 0);
        step("R2", 0, 1, 'h61, 'h12, 0, 0, 0);
        step("R2", 0, 0, 'h61, 0, 0, 0, 0);
        crd("R2", 'h30); crd("R2", 'h61);

        // R3: program bases and read back
        cwr("R3", 'h60, 'h03); cwr("R3", 'h61, 'h00);
        cwr("R3", 'h66, 'h02); cwr("R3", 'h67, 'h21);
        cwr("R3", 'h6E, 'hFF); cwr("R3", 'h6F, 'hFC);
        for (int k = 'h60; k < 'h70; k++) crd("R3", k);

        // R4 and R5: control registers with reserved bits
        cwr("R4", 'h30, 'hFE); crd("R4", 'h30);
        cwr("R4", 'h30, 'hFF); crd("R4", 'h30);
        cwr("R4", 'h30, 'h00);
        cwr("R5", 'h31, 'hFF); crd("R5", 'h31);
        cwr("R5", 'h31, 'h02); crd("R5", 'h31);

        // R11: unmapped indexes
        crd("R11", 'h32); crd("R11", 'h5F); crd("R11", 'h70); crd("R11", 'h00);

        // R6, R9: probe answers 0xAA around each window edge, reads and writes
        sweep("R6", 'h0300, 0); sweep("R6", 'h0221, 0); sweep("R6", 'hFFFC, 0);
        sweep("R9", 'h0300, 1);
        // R9: probe byte 0x55
        cwr("R9", 'h31, 'h03);
        sweep("R9", 'h0221, 0);

        // R7: zero base never matches
        sweep("R7", 'h0000, 0);
        cwr("R7", 'h60, 'h00); cwr("R7", 'h61, 'h00);
        sweep("R7", 'h0300, 0);

        // R10, R8: enabled device selects, probe suppressed
        cwr("R10", 'h30, 'h01);
        sweep("R10", 'h0221, 0);
        sweep("R8", 'hFFFC, 1);
        step("R8", 0, 0, 0, 0, 'h0222, 0, 0);
        step("R8", 0, 0, 0, 0, 'hFFFB, 1, 1);

        // R9: probe disarmed while disabled gives no answer
        cwr("R9", 'h30, 'h00); cwr("R9", 'h31, 'h01);
        sweep("R9", 'h0221, 0);

        // R1: reset again clears everything
        rst_n = 1'b0;
        step("R1", 1, 1, 'h30, 'h01, 0, 0, 0);
        for (int i = 0; i < 8; i++) base_m[i] = 0;
        en_m = 0; arm_m = 0; psel_m = 0;
        rst_n = 1'b1;
        crd("R1", 'h30); crd("R1", 'h67); crd("R1", 'h31);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule